// File: doc/BRIEF.md
# PLL Control Register with Lock Timer

This block is the software-visible control and status byte for an on-chip PLL, together with a behavioural timer that stands in for the analog lock detector. A byte-wide bus supplies an address, a write strobe and write data. Read data comes back combinationally for the decoded address. The byte holds a frequency-select bit and an enable bit, and it reports a read-only lock flag. The remaining upper bits are inert.

While the PLL is enabled, the block keeps a request to the reference RC oscillator asserted. It then counts a fixed lock interval, given in register-clock cycles, before it raises the lock flag and the enable for the gated fast-peripheral clock. The interval starts again whenever the enable becomes active or the frequency select changes while enabled. When the PLL is selected as the system clock, the enable is held on. The reset value of the enable comes from a fuse-derived input. The analog PLL, the oscillator and any clock multiplexing stay outside the block; only their request and status pins appear here. All pins are plain level signals. There is no streaming interface, so no back-pressure rules apply.

Top module: `pll_ctrl_top`

## Requirements
- R1: The register responds only at address `REG_ADDR` (default 0x29). A read at any other address returns 0x00, and a write at any other address changes nothing.
- R2: Bits 7 to 3 of the register always read as zero, whatever value was written to them.
- R3: Bit 2 selects the frequency: 1 selects the 64 MHz setting and 0 selects 32 MHz. It is read/write, resets to 0, and is driven on `pll_fast`.
- R4: Bit 1 is the enable and is read/write. Its reset value is taken from `en_rst_val`. `pll_en` and `ref_osc_req` both equal the bit as it reads.
- R5: While `pll_is_sysclk` is 1, bit 1 reads as 1 in the same cycle, and a write of 0 to it has no effect. Once `pll_is_sysclk` falls, the bit stays 1 until software clears it.
- R6: Bit 0 is the lock flag. Writes to bit 0 have no effect, and the flag resets to 0.
- R7: The enable is set by a write at clock edge E. The lock flag reads 0 up to and including the cycle after edge E+LOCK_CYCLES-1, and reads 1 from edge E+LOCK_CYCLES on. `fastclk_en` always equals the lock flag. LOCK_CYCLES must be at least 2.
- R8: In the cycle in which the enable reads 0, the lock flag and `fastclk_en` are already 0. A later re-enable waits out the full interval again.
- R9: A write that changes bit 2 while enabled drops the lock flag in the cycle after the write edge and restarts the full interval. A write that leaves bit 2 unchanged does not disturb a held lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| en_rst_val | input | 1 | Fuse-derived reset value of the enable bit |
| pll_is_sysclk | input | 1 | High while the PLL drives the system clock |
| pll_en | output | 1 | Run request to the PLL |
| ref_osc_req | output | 1 | Request to start the reference RC oscillator |
| pll_fast | output | 1 | Frequency select to the PLL (1 = 64 MHz) |
| fastclk_en | output | 1 | Permission to gate on the fast-peripheral PLL clock |

## Verification
Some properties are checked by assertions on every cycle. Off-address reads return zero, and the reserved bits read zero. The system-clock input leaves the stored enable set. The lock flag implies the enable, and a held lock always sits at the full count. Dropping the enable, a restart, or the absence of a write each leaves a fixed register state one edge later. The exact edge on which the lock rises, relock after a change of frequency, the absence of a relock when the same frequency is rewritten, and both reset values of the enable need the bench's scenarios. The bench compares every read against a cycle model built from the requirements.

// File: rtl/pllcr_pkg.sv
package pllcr_pkg;
  localparam int DATA_W  = 8;
  localparam int BIT_LCK = 0;
  localparam int BIT_EN  = 1;
  localparam int BIT_FAC = 2;

  typedef struct packed {
    logic fac;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pllcr_bus_port.sv
module pllcr_bus_port
  import pllcr_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 6'h29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  ctrl_t             rd_ctrl,
  input  logic              rd_lock,
  output logic              wr_hit,
  output ctrl_t             wr_ctrl,
  output logic [DATA_W-1:0] rdata
);
  localparam int RSVD_W = DATA_W - 3;

  logic hit;
  logic unused_wbits;

  assign hit            = (addr == REG_ADDR);
  assign wr_hit         = hit & we;
  assign wr_ctrl.fac    = wdata[BIT_FAC];
  assign wr_ctrl.en     = wdata[BIT_EN];
  assign unused_wbits   = ^{wdata[DATA_W-1:3], wdata[BIT_LCK]};

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[BIT_FAC] = rd_ctrl.fac;
      rdata[BIT_EN]  = rd_ctrl.en;
      rdata[BIT_LCK] = rd_lock;
    end
  end

  // R1: other addresses read as zero
  p_offaddr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != REG_ADDR) |-> (rdata == '0));
  // R2: reserved field reads as zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:DATA_W-RSVD_W] == '0);
endmodule

// File: rtl/pllcr_ctrl_regs.sv
module pllcr_ctrl_regs
  import pllcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_rst_val,
  input  logic  force_en,
  input  logic  wr_hit,
  input  ctrl_t wr_ctrl,
  output ctrl_t ctrl_o
);
  logic en_q;
  logic fac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= en_rst_val;
      fac_q <= 1'b0;
    end else begin
      if (force_en)    en_q <= 1'b1;
      else if (wr_hit) en_q <= wr_ctrl.en;
      if (wr_hit)      fac_q <= wr_ctrl.fac;
    end
  end

  assign ctrl_o.en  = en_q | force_en;
  assign ctrl_o.fac = fac_q;

  // R5: system-clock selection leaves the stored enable set
  p_force_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |=> en_q);
  // R3: factor only changes on a decoded write
  p_fac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(fac_q));
endmodule

// File: rtl/pllcr_lock_timer.sv
module pllcr_lock_timer #(
  parameter int LOCK_CYCLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_on,
  input  logic fac,
  output logic lock_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIM      = CNT_W'(LOCK_CYCLES);
  localparam logic [CNT_W-1:0] LIM_M1   = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             lock_q;
  logic             en_d;
  logic             fac_d;
  logic             restart;

  assign restart = pll_on & (~en_d | (fac != fac_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      lock_q <= 1'b0;
      en_d   <= 1'b0;
      fac_d  <= 1'b0;
    end else begin
      en_d  <= pll_on;
      fac_d <= fac;
      if (!pll_on) begin
        cnt    <= '0;
        lock_q <= 1'b0;
      end else if (restart) begin
        cnt    <= CNT_W'(1);
        lock_q <= 1'b0;
      end else if (cnt != LIM) begin
        cnt <= cnt + 1'b1;
        if (cnt == LIM_M1) lock_q <= 1'b1;
      end
    end
  end

  assign lock_o = lock_q & pll_on & ~restart;

  // R8: a dropped enable clears the held lock at the next edge
  p_lock_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |=> !lock_q);
  // R9: a restart reloads the interval from its first step
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == CNT_W'(1)) && !lock_q);
  // R7: a held lock only exists at the full count
  p_lock_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (cnt == LIM));
endmodule

// File: rtl/pll_ctrl_top.sv
module pll_ctrl_top
  import pllcr_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 6'h29,
  parameter int          LOCK_CYCLES = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              en_rst_val,
  input  logic              pll_is_sysclk,
  output logic              pll_en,
  output logic              ref_osc_req,
  output logic              pll_fast,
  output logic              fastclk_en
);
  logic  wr_hit;
  ctrl_t wr_ctrl;
  ctrl_t ctrl;
  logic  lock;

  pllcr_bus_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rd_ctrl(ctrl), .rd_lock(lock), .wr_hit(wr_hit), .wr_ctrl(wr_ctrl),
    .rdata(bus_rdata)
  );

  pllcr_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .en_rst_val(en_rst_val), .force_en(pll_is_sysclk),
    .wr_hit(wr_hit), .wr_ctrl(wr_ctrl), .ctrl_o(ctrl)
  );

  pllcr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .pll_on(ctrl.en), .fac(ctrl.fac), .lock_o(lock)
  );

  assign pll_en      = ctrl.en;
  assign ref_osc_req = ctrl.en;
  assign pll_fast    = ctrl.fac;
  assign fastclk_en  = lock;

  // R7: fast clock permission never without a running PLL
  p_fast_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fastclk_en |-> pll_en);
  // R5: forced enable is visible at the run request
  p_sysclk_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_is_sysclk |-> ref_osc_req);
endmodule

// File: tb/pll_ctrl_top_test.sv
`timescale 1ns/1ps
module pll_ctrl_top_test;
  localparam int LOCK = 12;
  localparam logic [5:0] REGA = 6'h29;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       en_rst_val = 1'b0;
  logic       pll_is_sysclk = 1'b0;
  logic       pll_en, ref_osc_req, pll_fast, fastclk_en;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic m_en, m_fac, pv, pf;
  int   since;
  string lock_tag = "R7";

  always #5 clk = ~clk;

  pll_ctrl_top #(.ADDR_W(6), .REG_ADDR(REGA), .LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_rst_val(en_rst_val),
    .pll_is_sysclk(pll_is_sysclk), .pll_en(pll_en), .ref_osc_req(ref_osc_req),
    .pll_fast(pll_fast), .fastclk_en(fastclk_en)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(logic f, logic e, logic l);
    return {5'b00000, f, e, l};
  endfunction

  // begins and ends just after a falling edge
  task automatic cyc(logic [5:0] a, logic we, logic [7:0] wd, logic sel);
    logic v, rs, el;
    bus_addr = a; bus_we = we; bus_wdata = wd; pll_is_sysclk = sel;
    #1;
    v  = m_en | sel;
    rs = v && (!pv || (m_fac != pf));
    if (!v || rs) since = 0;
    else if (since < LOCK) since++;
    el = v && !rs && (since >= LOCK);
    if (a == REGA) begin
      chk("R2", "reserved", {3'b000, bus_rdata[7:3]}, 8'h00);
      chk("R3", "factor bit", {7'd0, bus_rdata[2]}, {7'd0, m_fac});
      chk(sel ? "R5" : "R4", "enable bit", {7'd0, bus_rdata[1]}, {7'd0, v});
      chk(lock_tag, "lock bit", {7'd0, bus_rdata[0]}, {7'd0, el});
    end else begin
      chk("R1", "off-address read", bus_rdata, 8'h00);
    end
    chk(lock_tag, "fastclk_en", {7'd0, fastclk_en}, {7'd0, el});
    chk(sel ? "R5" : "R4", "pll_en/req", {6'd0, pll_en, ref_osc_req}, {6'd0, v, v});
    chk("R3", "pll_fast", {7'd0, pll_fast}, {7'd0, m_fac});
    pv = v; pf = m_fac;
    @(posedge clk);
    if (sel) m_en = 1'b1;
    else if (we && a == REGA) m_en = wd[1];
    if (we && a == REGA) m_fac = wd[2];
    @(negedge clk);
  endtask

  task automatic do_reset(logic fuse);
    @(negedge clk);
    rst_n = 1'b0; en_rst_val = fuse; bus_we = 1'b0; pll_is_sysclk = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_en = fuse; m_fac = 1'b0; pv = 1'b0; pf = 1'b0; since = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(REGA, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    int sel_left;
    seed_dummy = $urandom(32'h0000_2929);

    // R4: reset with enable fuse clear, everything reads zero
    do_reset(1'b0);
    chk("R4", "reset read", bus_rdata, 8'h00);
    idle(3);

    // R6: writing the lock bit while disabled has no effect
    lock_tag = "R6";
    cyc(REGA, 1'b1, 8'h01, 1'b0);
    idle(LOCK + 3);

    // R2, R7: write all ones, reserved stay zero, lock after full interval
    lock_tag = "R7";
    cyc(REGA, 1'b1, 8'hFF, 1'b0);
    idle(LOCK + 4);

    // R9: same factor rewritten keeps lock, changed factor relocks
    lock_tag = "R9";
    cyc(REGA, 1'b1, 8'h06, 1'b0);
    idle(2);
    cyc(REGA, 1'b1, 8'h02, 1'b0);
    idle(LOCK + 3);

    // R1: writes elsewhere leave the register alone
    cyc(6'h28, 1'b1, 8'h00, 1'b0);
    cyc(6'h2A, 1'b1, 8'h04, 1'b0);
    idle(2);

    // R8: clear the enable while locked, then re-enable
    lock_tag = "R8";
    cyc(REGA, 1'b1, 8'h00, 1'b0);
    idle(3);
    cyc(REGA, 1'b1, 8'h02, 1'b0);
    idle(LOCK + 3);
    cyc(REGA, 1'b1, 8'h00, 1'b0);

    // R5: system clock forces enable, clearing ignored
    lock_tag = "R7";
    for (int i = 0; i < LOCK + 4; i++) cyc(REGA, (i % 3) == 0, 8'h00, 1'b1);
    idle(4);

    // R4: reset with enable fuse set
    do_reset(1'b1);
    chk("R4", "reset read fuse", bus_rdata, 8'h02);
    idle(LOCK + 3);

    // random mix
    sel_left = 0;
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] a;
      logic       we;
      logic       s;
      a  = ($urandom % 4 != 0) ? REGA : 6'($urandom);
      we = ($urandom % 16) == 0;
      if (sel_left > 0) sel_left--;
      else if (($urandom % 200) == 0) sel_left = 10 + ($urandom % 30);
      s = (sel_left > 0);
      cyc(a, we, 8'($urandom), s);
    end

    summary();
    $finish;
  end
endmodule